// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Monitor

This block is the receive buffer on the destination side of a stream-to-memory DMA channel. Words arrive from an input stream under a valid/ready handshake and are held in a 128-entry, 32-bit FIFO. The memory side drains the FIFO through a second valid/ready handshake. Only that drain handshake is modelled here, not the memory write transactions behind it.

The block tracks the number of words it holds and compares that count against two programmable limits. The first is a general watermark. The second is a flow-control threshold whose flag tells the upstream loopback producer to hold off. A stream-pause input stops words from entering the FIFO. Draining continues while the stream is paused.

Top module: `dst_rx_level_mon`

## Requirements
- R1: While `rst` is high and at the first sample after it, `fill_level` is 0, `out_valid` is 0, and `wmark_hit` and `fc_hit` are 0.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when the FIFO holds 128 words or `strm_pause` is high. The FIFO holds at most 128 words.
- R3: `out_valid` is high exactly when the FIFO is not empty. `out_data` shows the oldest held word. A word is removed on an edge where `out_valid` and `out_ready` are both high. Words leave in the order they arrived.
- R4: `fill_level` equals the number of words held. It changes at the same edge as the transfer that alters it, and it stays unchanged when one word enters and one leaves at the same edge.
- R5: The flow-control code `fc_code` (7 bits) selects a threshold of code + 1 entries. `fc_hit` is high exactly when `fill_level` is at or above that threshold. The legal codes are 0x10 to 0x7A, which give 17 to 123 entries.
- R6: A flow-control code below 0x10 acts as 0x10. A code above 0x7A acts as 0x7A.
- R7: `wmark_hit` is high exactly when `fill_level` is at or above `wmark_lvl`. A watermark of 0 keeps the flag high. Values above 128 act as 128.
- R8: While `strm_pause` is high, no word enters, even with `in_valid` high. Words can still be drained. Clearing `strm_pause` restores acceptance.

Both flags are registered. They reflect the level and thresholds that are present after the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input stream word valid |
| in_data | input | 32 | Input stream word |
| in_ready | output | 1 | FIFO can take a word |
| strm_pause | input | 1 | Stops the stream-to-FIFO path |
| out_valid | output | 1 | Drain side has a word |
| out_data | output | 32 | Oldest held word |
| out_ready | input | 1 | Drain side takes the word |
| wmark_lvl | input | 8 | Watermark level, 0 to 128 |
| fc_code | input | 7 | Flow-control threshold code |
| fill_level | output | 8 | Number of words held |
| wmark_hit | output | 1 | Level at or above the watermark |
| fc_hit | output | 1 | Level at or above the flow-control threshold |

## Verification
The bench builds the block with its default parameters: 32-bit words, a depth of 128 and a 7-bit flow-control code. This lets it fill the FIFO completely and hit both ends of the legal code range, 17 and 123 entries. With the full 7-bit code it can also drive codes below and above that range and watermark values past 128. Directed phases fill the FIFO to full, drain it while paused, and empty it with the watermark at 0. A long random phase then mixes pushes, pops, pauses and changing thresholds.

// File: rtl/dst_mon_pkg.sv
package dst_mon_pkg;
  // Bound a value into the closed range [lo, hi].
  function automatic int unsigned clamp_u(input int unsigned v,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/dmon_store.sv
module dmon_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  // Storage array has no reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/dmon_level.sv
module dmon_level #(
  parameter int DEPTH = 128,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level_q,
  output logic [LVL_W-1:0] level_d,
  output logic             full,
  output logic             empty
);
  always_comb begin
    unique case ({push, pop})
      2'b10:   level_d = level_q + LVL_W'(1);
      2'b01:   level_d = level_q - LVL_W'(1);
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  assign full  = (level_q == LVL_W'(DEPTH));
  assign empty = (level_q == '0);
endmodule

// File: rtl/dmon_cmp.sv
module dmon_cmp #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level_d,
  input  logic [LVL_W-1:0] limit,
  output logic             hit
);
  // Compare the next level so the flag lines up with fill_level.
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= (level_d >= limit);
  end
endmodule

// File: rtl/dst_rx_level_mon.sv
module dst_rx_level_mon
  import dst_mon_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 128,
  parameter int CODE_W     = 7,
  parameter int FC_CODE_LO = 16,
  parameter int FC_CODE_HI = 122,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              strm_pause,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic [LVL_W-1:0]  wmark_lvl,
  input  logic [CODE_W-1:0] fc_code,
  output logic [LVL_W-1:0]  fill_level,
  output logic              wmark_hit,
  output logic              fc_hit
);
  logic             push, pop, full, empty;
  logic [LVL_W-1:0] level_d;
  logic [LVL_W-1:0] fc_limit, wm_limit;

  assign in_ready  = ~full & ~strm_pause;
  assign out_valid = ~empty;
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;

  // Code c selects c+1 entries after clamping to the legal range.
  assign fc_limit = LVL_W'(clamp_u(int'(fc_code), FC_CODE_LO, FC_CODE_HI) + 1);
  assign wm_limit = LVL_W'(clamp_u(int'(wmark_lvl), 0, DEPTH));

  dmon_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .wdata(in_data),
    .pop(pop), .rdata(out_data)
  );

  dmon_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .level_q(fill_level), .level_d(level_d), .full(full), .empty(empty)
  );

  dmon_cmp #(.LVL_W(LVL_W)) u_cmp_wm (
    .clk(clk), .rst(rst), .level_d(level_d), .limit(wm_limit), .hit(wmark_hit)
  );

  dmon_cmp #(.LVL_W(LVL_W)) u_cmp_fc (
    .clk(clk), .rst(rst), .level_d(level_d), .limit(fc_limit), .hit(fc_hit)
  );
endmodule

// File: rtl/dst_rx_level_mon_chk.sv
module dst_rx_level_mon_chk #(
  parameter int DEPTH      = 128,
  parameter int CODE_W     = 7,
  parameter int FC_CODE_LO = 16,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             strm_pause,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LVL_W-1:0] wmark_lvl,
  input logic [LVL_W-1:0] fill_level,
  input logic             wmark_hit,
  input logic             fc_hit
);
  logic seen;
  always_ff @(posedge clk) seen <= ~rst;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill_level <= LVL_W'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (fill_level == LVL_W'(DEPTH)) |-> !in_ready); // R2
  AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    strm_pause |-> !in_ready); // R8
  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (fill_level == '0) |-> !out_valid); // R3
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    seen |-> (fill_level == $past(fill_level)
              + LVL_W'($past(in_valid && in_ready))
              - LVL_W'($past(out_valid && out_ready)))); // R4
  AST_FC_FLOOR: assert property (@(posedge clk) disable iff (rst)
    fc_hit |-> (fill_level >= LVL_W'(FC_CODE_LO + 1))); // R6
  AST_WM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(wmark_lvl) == '0) |-> wmark_hit); // R7
endmodule

bind dst_rx_level_mon dst_rx_level_mon_chk #(
  .DEPTH(DEPTH), .CODE_W(CODE_W), .FC_CODE_LO(FC_CODE_LO)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .strm_pause(strm_pause), .out_valid(out_valid), .out_ready(out_ready),
  .wmark_lvl(wmark_lvl), .fill_level(fill_level),
  .wmark_hit(wmark_hit), .fc_hit(fc_hit)
);

// File: tb/dst_rx_level_mon_tb.sv
`timescale 1ns/1ps
module dst_rx_level_mon_tb;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        strm_pause = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;
  logic [7:0]  wmark_lvl = 8'd64;
  logic [6:0]  fc_code = 7'h40;
  logic [7:0]  fill_level;
  logic        wmark_hit, fc_hit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] qmem [DEPTH];
  int head = 0;
  int cnt = 0;

  always #10 clk = ~clk;

  dst_rx_level_mon u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .strm_pause(strm_pause), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .wmark_lvl(wmark_lvl),
    .fc_code(fc_code), .fill_level(fill_level), .wmark_hit(wmark_hit),
    .fc_hit(fc_hit)
  );

  function automatic bit exp_fc(int lvl, int code);
    int c = code < 16 ? 16 : (code > 122 ? 122 : code);
    return lvl >= c + 1;
  endfunction

  function automatic bit exp_wm(int lvl, int wm);
    int w = wm > DEPTH ? DEPTH : wm;
    return lvl >= w;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle, advance the model at the edge, check at the following negedge.
  task automatic cycle(input int pv, input int pr, input bit pz);
    bit exp_rdy, push, pop;
    in_valid   = ($urandom_range(99) < pv);
    in_data    = $urandom;
    out_ready  = ($urandom_range(99) < pr);
    strm_pause = pz;
    #1;
    exp_rdy = (cnt < DEPTH) && !pz;
    chk(in_ready == exp_rdy, pz ? "R8 ready while paused" : "R2 ready", in_ready, exp_rdy);
    push = in_valid && exp_rdy;
    pop  = (cnt > 0) && out_ready;
    @(posedge clk);
    if (push) qmem[(head + cnt) % DEPTH] = in_data;
    if (pop)  head = (head + 1) % DEPTH;
    cnt = cnt + int'(push) - int'(pop);
    @(negedge clk);
    chk(int'(fill_level) == cnt, "R4 level", fill_level, cnt);
    chk(out_valid == (cnt > 0), "R3 out_valid", out_valid, cnt > 0);
    if (cnt > 0) chk(out_data == qmem[head], "R3 order", out_data, qmem[head]);
    chk(fc_hit == exp_fc(cnt, fc_code), "R5/R6 fc_hit", fc_hit, exp_fc(cnt, fc_code));
    chk(wmark_hit == exp_wm(cnt, wmark_lvl), "R7 wmark_hit", wmark_hit,
        exp_wm(cnt, wmark_lvl));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(fill_level == 0, "R1 level", fill_level, 0);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(wmark_hit == 0 && fc_hit == 0, "R1 flags", {wmark_hit, fc_hit}, 0);
    rst = 1'b0;
    // R2 fill to full with top-end thresholds (123 entries, watermark 128)
    wmark_lvl = 8'd128; fc_code = 7'h7A;
    repeat (200) cycle(100, 0, 1'b0);
    chk(fill_level == 8'd128, "R2 capacity", fill_level, 128);
    // R8 paused while draining, lowest legal code and watermark 100
    wmark_lvl = 8'd100; fc_code = 7'h10;
    repeat (40) cycle(100, 100, 1'b1);
    // R6 codes below and above the legal range
    fc_code = 7'h00;
    repeat (30) cycle(100, 30, 1'b0);
    fc_code = 7'h7F; wmark_lvl = 8'd200;
    repeat (60) cycle(100, 0, 1'b0);
    // random mix with changing thresholds
    for (int k = 0; k < 40; k++) begin
      fc_code   = 7'($urandom_range(127));
      wmark_lvl = 8'($urandom_range(255));
      repeat (50) cycle(60, 50, ($urandom_range(99) < 15));
    end
    // R7 watermark 0 while draining to empty
    wmark_lvl = 8'd0;
    repeat (200) cycle(0, 100, 1'b0);
    chk(fill_level == 0, "R3 drained", fill_level, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule